// File: doc/BRIEF.md
# Hot-Swap Power Sequencing Controller

This block is the digital control core of a hot-swap controller for a supply rail. It watches four digitised status flags from the analog front end: undervoltage, overvoltage, current limit reached and severe short. It also watches an active-low power-good signal that comes back from the downstream converter. From these it drives the pass-gate enable and two sequenced power-good outputs. A sticky fault register records why the gate was removed.

All timed behaviour comes from a single delay timer. The timer runs at one, two or four times a nominal delay, and `NOM_CYCLES` sets that nominal delay in clock cycles. These timed intervals are:
- the start-up wait before the gate turns on;
- the gap between the first and the second power-good;
- the watchdog window in which the converter must answer;
- the auto-retry pause, whose length depends on which fault occurred.

A separate circuit-breaker counter measures how long the current-limit flag stays asserted without a break. Analog current control, soft-start, inrush shaping and any register bus are outside this block.

Top module: `hot_swap_seq`

## Requirements
- R1: After reset `gateEn`, `pgOut1` and `pgOut2` are low and `faultReg` is 4'b0000.
- R2: The supply counts as valid when `uvFlag` and `ovFlag` are both low. `gateEn` and `pgOut1` rise together `NOM_CYCLES` clock edges after the first edge that sees a valid supply. If the supply becomes invalid during that wait, the block returns to waiting and logs no fault.
- R3: `pgOut2` rises exactly 2*`NOM_CYCLES` edges after `pgOut1` rises.
- R4: When `pgOut2` rises, a window of 4*`NOM_CYCLES` edges starts. If `convGoodN` is sampled low within the window, the gate stays on. Otherwise the gate drops at the end of the window and bit 3 (power bad) of `faultReg` is set.
- R5: While the gate is on, `limFlag` sampled high on `CB_CYCLES` consecutive edges removes the gate on the last of those edges and sets bit 2 (overcurrent). A low sample resets the count, so shorter bursts have no effect.
- R6: `shortFlag` high removes `gateEn`, `pgOut1` and `pgOut2` in the same cycle with no clock edge. The next edge sets bit 2 (overcurrent).
- R7: `uvFlag` high while the gate is on removes the gate at the next edge and sets bit 0 (undervoltage).
- R8: `ovFlag` high while the gate is on removes the gate at the next edge and sets bit 1 (overvoltage). Recovery does not depend on `autoRetry` and has no retry pause. Once the supply is valid again, the start-up delay of R2 runs.
- R9: With `autoRetry` high, a fault is followed by a pause and then the start-up delay. The pause is `NOM_CYCLES` for undervoltage or power bad and 4*`NOM_CYCLES` for overcurrent. The gate therefore returns 2*`NOM_CYCLES` or 5*`NOM_CYCLES` edges after the fault edge.
- R10: With `autoRetry` low, a non-overvoltage fault keeps the gate off until `faultClr` is sampled high. The start-up delay then runs from that edge.
- R11: Fault bits stay set until an edge samples `faultClr` high. That edge clears all four bits. If a bit is set and cleared in the same cycle, setting wins.
- R12: `pgOut1` and `pgOut2` are low whenever `gateEn` is low, and `pgOut2` is never high without `pgOut1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rstN | input | 1 | Asynchronous active-low reset |
| uvFlag | input | 1 | Supply undervoltage flag |
| ovFlag | input | 1 | Supply overvoltage flag |
| limFlag | input | 1 | Current limit reached |
| shortFlag | input | 1 | Severe short circuit detected |
| convGoodN | input | 1 | Active-low power-good returned by the downstream converter |
| autoRetry | input | 1 | 1: retry after a timed pause, 0: stay latched off |
| faultClr | input | 1 | Clears all fault bits when sampled high |
| gateEn | output | 1 | Pass-gate enable |
| pgOut1 | output | 1 | First power-good output |
| pgOut2 | output | 1 | Second, sequenced power-good output |
| faultReg | output | 4 | Sticky faults: [0] undervoltage, [1] overvoltage, [2] overcurrent, [3] power bad |

## Verification
The bench builds the block with `NOM_CYCLES` = 20 and `CB_CYCLES` = 10. With these values every 1x, 2x, 4x and 5x interval finishes within a few hundred cycles, so the bench can count each interval edge by edge and compare it with the exact figure. The breaker can be driven with bursts of exactly one cycle less than the trip length, which shows that the counter restarts after each burst. All fault paths, including the full watchdog expiry and the latched-off case with manual clear, fit into a single short run.

// File: rtl/hot_swap_pkg.sv
package hot_swap_pkg;

  localparam int FAULT_BITS = 4;
  localparam int F_UV = 0;
  localparam int F_OV = 1;
  localparam int F_OC = 2;
  localparam int F_PB = 3;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_START  = 3'd1,
    S_PG1    = 3'd2,
    S_PG2    = 3'd3,
    S_UP     = 3'd4,
    S_RETRY  = 3'd5,
    S_LATCH  = 3'd6,
    S_OVWAIT = 3'd7
  } seqState_t;

  typedef enum logic [1:0] {
    MULT_1X = 2'd0,
    MULT_2X = 2'd1,
    MULT_4X = 2'd2
  } tmrMult_t;

  typedef struct packed {
    logic                  tmrStart;
    tmrMult_t              tmrMult;
    logic                  breakerArm;
    logic [FAULT_BITS-1:0] faultSet;
  } ctrlStrobes_t;

endpackage

// File: rtl/hot_swap_datapath.sv
module hot_swap_datapath
  import hot_swap_pkg::*;
#(
  parameter int NOM_CYCLES = 1000,
  parameter int CB_CYCLES  = 530
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          strobes,
  input  logic                  limFlag,
  input  logic                  faultClr,
  output logic                  tmrDone,
  output logic                  cbTrip,
  output logic [FAULT_BITS-1:0] faultReg
);

  localparam int TMR_W = $clog2(4 * NOM_CYCLES + 1);
  localparam int CB_W  = $clog2(CB_CYCLES + 1);
  localparam logic [TMR_W-1:0] LIM_1X = TMR_W'(NOM_CYCLES);
  localparam logic [TMR_W-1:0] LIM_2X = TMR_W'(2 * NOM_CYCLES);
  localparam logic [TMR_W-1:0] LIM_4X = TMR_W'(4 * NOM_CYCLES);
  localparam logic [CB_W-1:0]  CB_LAST = CB_W'(CB_CYCLES - 1);

  // Shared delay timer
  logic             tmrRun;
  logic [TMR_W-1:0] tmrCnt;
  logic [TMR_W-1:0] tmrLimit;
  logic [TMR_W-1:0] newLimit;

  always_comb begin
    case (strobes.tmrMult)
      MULT_2X: newLimit = LIM_2X;
      MULT_4X: newLimit = LIM_4X;
      default: newLimit = LIM_1X;
    endcase
  end

  assign tmrDone = tmrRun && (tmrCnt == (tmrLimit - TMR_W'(1)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrRun   <= 1'b0;
      tmrCnt   <= '0;
      tmrLimit <= LIM_1X;
    end else if (strobes.tmrStart) begin
      tmrRun   <= 1'b1;
      tmrCnt   <= '0;
      tmrLimit <= newLimit;
    end else if (tmrDone) begin
      tmrRun <= 1'b0;
    end else if (tmrRun) begin
      tmrCnt <= tmrCnt + TMR_W'(1);
    end
  end

  // Circuit-breaker: consecutive cycles of current limit while the gate is on
  logic [CB_W-1:0] cbCnt;

  assign cbTrip = strobes.breakerArm && limFlag && (cbCnt == CB_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cbCnt <= '0;
    end else if (!strobes.breakerArm || !limFlag) begin
      cbCnt <= '0;
    end else if (cbCnt != CB_LAST) begin
      cbCnt <= cbCnt + CB_W'(1);
    end
  end

  // Sticky fault bits, set wins over clear
  for (genvar b = 0; b < FAULT_BITS; b++) begin : g_fault
    logic bitQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bitQ <= 1'b0;
      end else if (strobes.faultSet[b]) begin
        bitQ <= 1'b1;
      end else if (faultClr) begin
        bitQ <= 1'b0;
      end
    end
    assign faultReg[b] = bitQ;
  end

endmodule

// File: rtl/hot_swap_ctrl.sv
module hot_swap_ctrl
  import hot_swap_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         uvFlag,
  input  logic         ovFlag,
  input  logic         shortFlag,
  input  logic         convGoodN,
  input  logic         autoRetry,
  input  logic         faultClr,
  input  logic         tmrDone,
  input  logic         cbTrip,
  output ctrlStrobes_t strobes,
  output logic         gateEn,
  output logic         pgOut1,
  output logic         pgOut2
);

  seqState_t state;
  seqState_t nextState;
  logic      supplyOk;
  logic      gateState;
  logic      faultHit;
  tmrMult_t  faultMult;

  assign supplyOk  = !uvFlag && !ovFlag;
  assign gateState = (state == S_PG1) || (state == S_PG2) || (state == S_UP);

  always_comb begin
    nextState          = state;
    strobes            = '0;
    strobes.tmrMult    = MULT_1X;
    strobes.breakerArm = gateState;
    faultHit           = 1'b0;
    faultMult          = MULT_1X;

    case (state)
      S_IDLE: begin
        if (supplyOk) begin
          nextState        = S_START;
          strobes.tmrStart = 1'b1;
        end
      end
      S_START: begin
        if (!supplyOk) begin
          nextState = S_IDLE;
        end else if (tmrDone) begin
          nextState        = S_PG1;
          strobes.tmrStart = 1'b1;
          strobes.tmrMult  = MULT_2X;
        end
      end
      S_PG1, S_PG2, S_UP: begin
        if (shortFlag || cbTrip) begin
          strobes.faultSet[F_OC] = 1'b1;
          faultHit               = 1'b1;
          faultMult              = MULT_4X;
        end else if (ovFlag) begin
          strobes.faultSet[F_OV] = 1'b1;
          nextState              = S_OVWAIT;
        end else if (uvFlag) begin
          strobes.faultSet[F_UV] = 1'b1;
          faultHit               = 1'b1;
        end else if (state == S_PG1) begin
          if (tmrDone) begin
            nextState        = S_PG2;
            strobes.tmrStart = 1'b1;
            strobes.tmrMult  = MULT_4X;
          end
        end else if (state == S_PG2) begin
          if (!convGoodN) begin
            nextState = S_UP;
          end else if (tmrDone) begin
            strobes.faultSet[F_PB] = 1'b1;
            faultHit               = 1'b1;
          end
        end
      end
      S_RETRY: begin
        if (tmrDone) begin
          if (supplyOk) begin
            nextState        = S_START;
            strobes.tmrStart = 1'b1;
          end else begin
            nextState = S_IDLE;
          end
        end
      end
      S_LATCH: begin
        if (faultClr) begin
          if (supplyOk) begin
            nextState        = S_START;
            strobes.tmrStart = 1'b1;
          end else begin
            nextState = S_IDLE;
          end
        end
      end
      S_OVWAIT: begin
        if (supplyOk) begin
          nextState        = S_START;
          strobes.tmrStart = 1'b1;
        end
      end
      default: nextState = S_IDLE;
    endcase

    if (faultHit) begin
      if (autoRetry) begin
        nextState        = S_RETRY;
        strobes.tmrStart = 1'b1;
        strobes.tmrMult  = faultMult;
      end else begin
        nextState = S_LATCH;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
    end else begin
      state <= nextState;
    end
  end

  // Short circuit cuts the gate without waiting for a clock edge
  assign gateEn = gateState && !shortFlag;
  assign pgOut1 = gateState && !shortFlag;
  assign pgOut2 = ((state == S_PG2) || (state == S_UP)) && !shortFlag;

endmodule

// File: rtl/hot_swap_seq.sv
module hot_swap_seq
  import hot_swap_pkg::*;
#(
  parameter int NOM_CYCLES = 1000,
  parameter int CB_CYCLES  = 530
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       uvFlag,
  input  logic       ovFlag,
  input  logic       limFlag,
  input  logic       shortFlag,
  input  logic       convGoodN,
  input  logic       autoRetry,
  input  logic       faultClr,
  output logic       gateEn,
  output logic       pgOut1,
  output logic       pgOut2,
  output logic [3:0] faultReg
);

  ctrlStrobes_t strobes;
  logic         tmrDone;
  logic         cbTrip;

  hot_swap_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .uvFlag   (uvFlag),
    .ovFlag   (ovFlag),
    .shortFlag(shortFlag),
    .convGoodN(convGoodN),
    .autoRetry(autoRetry),
    .faultClr (faultClr),
    .tmrDone  (tmrDone),
    .cbTrip   (cbTrip),
    .strobes  (strobes),
    .gateEn   (gateEn),
    .pgOut1   (pgOut1),
    .pgOut2   (pgOut2)
  );

  hot_swap_datapath #(
    .NOM_CYCLES(NOM_CYCLES),
    .CB_CYCLES (CB_CYCLES)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .limFlag (limFlag),
    .faultClr(faultClr),
    .tmrDone (tmrDone),
    .cbTrip  (cbTrip),
    .faultReg(faultReg)
  );

endmodule

// File: rtl/hot_swap_seq_chk.sv
module hot_swap_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       uvFlag,
  input logic       ovFlag,
  input logic       shortFlag,
  input logic       faultClr,
  input logic       gateEn,
  input logic       pgOut1,
  input logic       pgOut2,
  input logic [3:0] faultReg
);

  p_gate_rise_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateEn) |-> $past(!uvFlag && !ovFlag));

  p_pg2_after_pg1_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pgOut2) |-> $past(pgOut1));

  p_short_cut_r6: assert property (@(posedge clk) disable iff (!rstN)
    shortFlag |-> (!gateEn && !pgOut1 && !pgOut2));

  p_sticky_faults_r11: assert property (@(posedge clk) disable iff (!rstN)
    !faultClr |=> ((faultReg & $past(faultReg)) == $past(faultReg)));

  p_pg_needs_gate_r12: assert property (@(posedge clk) disable iff (!rstN)
    !gateEn |-> (!pgOut1 && !pgOut2));

  p_pg_order_r12: assert property (@(posedge clk) disable iff (!rstN)
    pgOut2 |-> pgOut1);

endmodule

bind hot_swap_seq hot_swap_seq_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .uvFlag   (uvFlag),
  .ovFlag   (ovFlag),
  .shortFlag(shortFlag),
  .faultClr (faultClr),
  .gateEn   (gateEn),
  .pgOut1   (pgOut1),
  .pgOut2   (pgOut2),
  .faultReg (faultReg)
);

// File: tb/hot_swap_seq_tb_top.sv
`timescale 1ns/1ps
module hot_swap_seq_tb_top;

  localparam int NOM = 20;
  localparam int CB  = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       uvFlag = 1'b1;
  logic       ovFlag = 1'b0;
  logic       limFlag = 1'b0;
  logic       shortFlag = 1'b0;
  logic       convGoodN = 1'b1;
  logic       autoRetry = 1'b1;
  logic       faultClr = 1'b0;
  logic       gateEn;
  logic       pgOut1;
  logic       pgOut2;
  logic [3:0] faultReg;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  hot_swap_seq #(.NOM_CYCLES(NOM), .CB_CYCLES(CB)) dut_i (
    .clk(clk), .rstN(rstN), .uvFlag(uvFlag), .ovFlag(ovFlag),
    .limFlag(limFlag), .shortFlag(shortFlag), .convGoodN(convGoodN),
    .autoRetry(autoRetry), .faultClr(faultClr), .gateEn(gateEn),
    .pgOut1(pgOut1), .pgOut2(pgOut2), .faultReg(faultReg)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic pick(input int sel);
    case (sel)
      1:       return pgOut1;
      2:       return pgOut2;
      default: return gateEn;
    endcase
  endfunction

  // Count negedge samples while the selected output is low (starts at current negedge)
  task automatic countLow(input int sel, output int n);
    n = 0;
    while (!pick(sel) && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic countHigh(input int sel, output int n);
    n = 0;
    while (pick(sel) && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; uvFlag = 1'b1; ovFlag = 1'b0; limFlag = 1'b0;
    shortFlag = 1'b0; convGoodN = 1'b1; faultClr = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic bringUp(input logic respond);
    int n;
    uvFlag = 1'b0;
    ovFlag = 1'b0;
    @(negedge clk);
    countLow(0, n);
    check("R2 start-up delay", n, NOM);
    check("R2 pg1 with gate", int'(pgOut1), 1);
    countLow(2, n);
    check("R3 pg2 sequencing delay", n, 2 * NOM);
    if (respond) convGoodN = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    check("R1 gate after reset", int'(gateEn), 0);
    check("R1 pg outputs after reset", int'({pgOut1, pgOut2}), 0);
    check("R1 faults after reset", int'(faultReg), 0);
    uvFlag = 1'b0;
    repeat (NOM / 2) @(negedge clk);
    uvFlag = 1'b1;
    repeat (2 * NOM) @(negedge clk);
    check("R2 aborted start keeps gate off", int'(gateEn), 0);
    check("R2 aborted start logs nothing", int'(faultReg), 0);
  endtask

  task automatic testWatchdogOk();
    doReset();
    autoRetry = 1'b1;
    bringUp(1'b1);
    repeat (6 * NOM) @(negedge clk);
    check("R4 converter answered, gate stays", int'(gateEn & pgOut2), 1);
    check("R4 converter answered, no fault", int'(faultReg), 0);
  endtask

  task automatic testWatchdogTrip();
    int n;
    doReset();
    autoRetry = 1'b0;
    bringUp(1'b0);
    countHigh(0, n);
    check("R4 watchdog window", n, 4 * NOM);
    check("R4 power bad bit", int'(faultReg), 8);
    check("R12 pg off with gate", int'({pgOut1, pgOut2}), 0);
    repeat (6 * NOM) @(negedge clk);
    check("R10 latched off", int'(gateEn), 0);
    check("R11 bit held", int'(faultReg), 8);
    faultClr = 1'b1;
    @(negedge clk);
    faultClr = 1'b0;
    check("R11 clear zeroes faults", int'(faultReg), 0);
    countLow(0, n);
    check("R10 restart after clear", n, NOM);
  endtask

  task automatic testBreaker();
    int n;
    doReset();
    autoRetry = 1'b1;
    bringUp(1'b1);
    limFlag = 1'b1;
    repeat (CB - 1) @(negedge clk);
    limFlag = 1'b0;
    @(negedge clk);
    limFlag = 1'b1;
    repeat (CB - 1) @(negedge clk);
    limFlag = 1'b0;
    repeat (3) @(negedge clk);
    check("R5 short bursts ignored: gate", int'(gateEn), 1);
    check("R5 short bursts ignored: faults", int'(faultReg), 0);
    limFlag = 1'b1;
    @(negedge clk);
    countHigh(0, n);
    limFlag = 1'b0;
    check("R5 breaker trip time", n, CB - 1);
    check("R5 overcurrent bit", int'(faultReg), 4);
    countLow(0, n);
    check("R9 overcurrent retry", n, 5 * NOM);
  endtask

  task automatic testShort();
    int n;
    doReset();
    autoRetry = 1'b1;
    bringUp(1'b1);
    shortFlag = 1'b1;
    #1;
    check("R6 immediate gate cut", int'(gateEn), 0);
    check("R6 R12 immediate pg cut", int'({pgOut1, pgOut2}), 0);
    @(negedge clk);
    shortFlag = 1'b0;
    check("R6 short logged as overcurrent", int'(faultReg), 4);
    countLow(0, n);
    check("R9 retry after short", n, 5 * NOM);
  endtask

  task automatic testUv();
    int n;
    doReset();
    autoRetry = 1'b1;
    bringUp(1'b1);
    uvFlag = 1'b1;
    @(negedge clk);
    check("R7 gate off on undervoltage", int'(gateEn), 0);
    check("R12 pg off on undervoltage", int'({pgOut1, pgOut2}), 0);
    check("R7 undervoltage bit", int'(faultReg), 1);
    uvFlag = 1'b0;
    countLow(0, n);
    check("R9 undervoltage retry", n, 2 * NOM);
  endtask

  task automatic testOv();
    int n;
    doReset();
    autoRetry = 1'b0;
    bringUp(1'b1);
    ovFlag = 1'b1;
    @(negedge clk);
    check("R8 gate off on overvoltage", int'(gateEn), 0);
    check("R8 overvoltage bit", int'(faultReg), 2);
    repeat (3 * NOM) @(negedge clk);
    check("R8 held off while overvoltage", int'(gateEn), 0);
    ovFlag = 1'b0;
    @(negedge clk);
    countLow(0, n);
    check("R8 recovery uses start-up delay only", n, NOM);
  endtask

  initial begin
    testReset();
    testWatchdogOk();
    testWatchdogTrip();
    testBreaker();
    testShort();
    testUv();
    testOv();
    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule